// File: doc/BRIEF.md
# Pseudo-Random Translation Entry Index Generator

This block picks a replacement slot in a translation table of `ENTRIES` entries. The lowest `wired` entries are reserved and must never be chosen. Each accepted request advances a 32-bit linear congruential generator once. The upper half of the new state is reduced modulo the number of unreserved entries, and the reserved count is then added. The result is always a slot at or above the reserved boundary and below the table size.

The reduction uses a one-bit-per-cycle restoring remainder unit. A controller with three states sequences it:

- `ST_IDLE` waits for a request. On `req` it takes the transition *accept* to `ST_DIV`, or the transition *clamp* to `ST_DONE` when the reserved count leaves no free entry.
- `ST_DIV` runs sixteen remainder steps. It takes the transition *finish* to `ST_DONE` after the last step.
- `ST_DONE` raises `valid` for one cycle and takes the transition *release* back to `ST_IDLE`.

Requests that arrive outside `ST_IDLE` are dropped.

Top module: `tlb_rand_idx`

## Requirements
- R1: After reset `valid` is 0, `idx` is 0 and the generator state is 0, so the first accepted request uses state value 1.
- R2: Each accepted request replaces the state with state*314159+1 modulo 2^32. The state does not change on any other cycle, however many idle cycles pass.
- R3: With wired < ENTRIES, the reported index equals (bits 31..16 of the new state mod (ENTRIES-wired)) + wired, so it lies in [wired, ENTRIES).
- R4: With wired >= ENTRIES, the reported index is ENTRIES-1 and no division is performed. The generator state still advances once.
- R5: With a request sampled at clock edge k, `valid` is high for exactly one cycle. On the normal path it rises at edge k+16; on the clamp path it rises at edge k.
- R6: A request seen in `ST_DIV` or `ST_DONE` is ignored and does not advance the state. The `wired` value is captured at acceptance, so later changes to `wired` do not affect the result in progress.
- R7: `idx` keeps its value from one `valid` pulse until the next.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 1 | Request for a new index, accepted only when idle |
| wired | input | $clog2(ENTRIES)+1 | Number of reserved low entries |
| idx | output | $clog2(ENTRIES) | Chosen entry index |
| valid | output | 1 | One-cycle pulse marking a fresh `idx` |

## Verification
The normal result is due 16 clock edges after the edge that samples `req`. A clamped result is due on that same edge. The bench drives `req` on a falling edge and counts falling edges until `valid` appears, expecting 17 or 1. It then checks that `valid` is low again one falling edge later and compares `idx` with a generator model run in the bench. Every wired value from 0 to 20 is swept against a 16-entry table. Extra requests and `wired` changes are injected in the middle of a computation, and a long idle gap is placed between requests; in each case the next index must still follow the model sequence.

// File: rtl/tlb_rand_pkg.sv
package tlb_rand_pkg;
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_DONE = 2'd2
    } rng_state_e;

    localparam logic [31:0] LCG_MUL = 32'd314159;
    localparam logic [31:0] LCG_INC = 32'd1;
    localparam int          DVD_W   = 16;
endpackage

// File: rtl/lcg_step.sv
module lcg_step #(
    parameter logic [31:0] MUL = 32'd314159,
    parameter logic [31:0] INC = 32'd1
) (
    input  logic [31:0] cur,
    output logic [31:0] nxt
);
    // Product truncated to 32 bits gives wrap modulo 2^32
    always_comb nxt = cur * MUL + INC;
endmodule

// File: rtl/mod_divider.sv
module mod_divider #(
    parameter int DVD_W = 16,
    parameter int DIV_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [DVD_W-1:0] dividend,
    input  logic [DIV_W-1:0] divisor,
    output logic [DIV_W-1:0] rem_nx
);
    logic [DVD_W-1:0] dvd_q;
    logic [DIV_W-1:0] rem_q;
    logic [DIV_W:0]   trial;

    always_comb begin
        trial = {rem_q, dvd_q[DVD_W-1]};
        if (trial >= {1'b0, divisor})
            rem_nx = DIV_W'(trial - {1'b0, divisor});
        else
            rem_nx = trial[DIV_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            rem_q <= '0;
        end else if (load) begin
            dvd_q <= dividend;
            rem_q <= '0;
        end else if (step) begin
            dvd_q <= {dvd_q[DVD_W-2:0], 1'b0};
            rem_q <= rem_nx;
        end
    end
endmodule

// File: rtl/tlb_rand_idx.sv
module tlb_rand_idx
    import tlb_rand_pkg::*;
#(
    parameter int ENTRIES = 16,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int WIRED_W = IDX_W + 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               req,
    input  logic [WIRED_W-1:0] wired,
    output logic [IDX_W-1:0]   idx,
    output logic               valid
);
    localparam int DIV_W   = WIRED_W;
    localparam int CNT_W   = $clog2(DVD_W);
    localparam logic [CNT_W-1:0]   LAST_STEP = CNT_W'(DVD_W - 1);
    localparam logic [WIRED_W-1:0] N_W       = WIRED_W'(ENTRIES);
    localparam logic [IDX_W-1:0]   TOP_IDX   = IDX_W'(ENTRIES - 1);

    rng_state_e         st_q, st_d;
    logic [31:0]        lcg_q, lcg_nx;
    logic [WIRED_W-1:0] wired_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [DIV_W-1:0]   divisor, rem_nx;
    logic               accept, in_range, last;

    assign accept   = (st_q == ST_IDLE) && req;
    assign in_range = wired < N_W;
    assign last     = (st_q == ST_DIV) && (cnt_q == LAST_STEP);
    assign divisor  = N_W - wired_q;

    lcg_step #(.MUL(LCG_MUL), .INC(LCG_INC)) u_lcg (
        .cur (lcg_q),
        .nxt (lcg_nx)
    );

    mod_divider #(.DVD_W(DVD_W), .DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .step     (st_q == ST_DIV),
        .dividend (lcg_nx[31:16]),
        .divisor  (divisor),
        .rem_nx   (rem_nx)
    );

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // Transitions: accept, clamp, finish, release
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (req) st_d = in_range ? ST_DIV : ST_DONE;
            ST_DIV:  if (last) st_d = ST_DONE;
            ST_DONE: st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb valid = (st_q == ST_DONE);

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lcg_q   <= '0;
            wired_q <= '0;
            cnt_q   <= '0;
            idx     <= '0;
        end else begin
            if (accept) begin
                lcg_q   <= lcg_nx;
                wired_q <= wired;
                cnt_q   <= '0;
                if (!in_range) idx <= TOP_IDX;
            end else if (st_q == ST_DIV) begin
                cnt_q <= cnt_q + 1'b1;
                if (last) idx <= IDX_W'(rem_nx + wired_q);
            end
        end
    end
endmodule

// File: rtl/tlb_rand_idx_chk.sv
module tlb_rand_idx_chk #(
    parameter int ENTRIES = 16,
    parameter int IDX_W   = 4,
    parameter int WIRED_W = 5
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req,
    input logic               valid,
    input logic [IDX_W-1:0]   idx,
    input logic [31:0]        lcg_q,
    input logic               idle,
    input logic [WIRED_W-1:0] wired_q
);
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        valid |=> !valid);

    a_r3_idx_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && wired_q < WIRED_W'(ENTRIES)) |->
            ({1'b0, idx} >= wired_q && int'(idx) < ENTRIES));

    a_r4_clamp_top: assert property (@(posedge clk) disable iff (!rst_n)
        (valid && wired_q >= WIRED_W'(ENTRIES)) |-> (int'(idx) == ENTRIES - 1));

    a_r7_idx_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !valid |=> (valid || $stable(idx)));

    a_r2_no_spurious_advance: assert property (@(posedge clk) disable iff (!rst_n)
        !(idle && req) |=> $stable(lcg_q));

    a_r6_busy_ignores: assert property (@(posedge clk) disable iff (!rst_n)
        (!idle && req) |=> $stable(lcg_q));
endmodule

bind tlb_rand_idx tlb_rand_idx_chk #(
    .ENTRIES (ENTRIES),
    .IDX_W   (IDX_W),
    .WIRED_W (WIRED_W)
) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .req     (req),
    .valid   (valid),
    .idx     (idx),
    .lcg_q   (lcg_q),
    .idle    (st_q == tlb_rand_pkg::ST_IDLE),
    .wired_q (wired_q)
);

// File: tb/tlb_rand_idx_test.sv
module tlb_rand_idx_test;
    localparam int CLK_PERIOD = 10;
    localparam int N  = 16;
    localparam int IW = $clog2(N);
    localparam int WW = IW + 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req = 1'b0;
    logic [WW-1:0] wired = '0;
    logic [IW-1:0] idx;
    logic          valid;

    int          checks = 0;
    int          fails  = 0;
    logic [31:0] seed   = 32'd0;

    always #(CLK_PERIOD/2) clk = ~clk;

    tlb_rand_idx #(.ENTRIES(N)) uut (
        .clk(clk), .rst_n(rst_n), .req(req), .wired(wired),
        .idx(idx), .valid(valid)
    );

    task automatic check(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Drives a request; poke adds a second request and a wired change mid-way (R6)
    task automatic do_req(input int w, input bit poke);
        int n;
        int exp_idx;
        int exp_lat;
        seed = seed * 32'd314159 + 32'd1;
        if (w >= N) exp_idx = N - 1;
        else        exp_idx = int'(seed[31:16]) % (N - w) + w;
        exp_lat = (w >= N) ? 1 : 17;
        @(negedge clk);
        wired = WW'(w);
        req = 1'b1;
        n = 0;
        while (1) begin
            @(negedge clk);
            n++;
            req = poke && (n == 4 || n == 16);
            if (poke && n == 4) wired = '0;
            if (valid || n > 40) break;
        end
        check(w >= N ? "R5 clamp latency" : "R5 latency", n, exp_lat);
        if (w >= N) check("R4 clamp index", int'(idx), exp_idx);
        else if (poke) check("R6 index unaffected by busy request", int'(idx), exp_idx);
        else check("R3 index", int'(idx), exp_idx);
        req = 1'b0;
        @(negedge clk);
        check("R5 valid one cycle", int'(valid), 0);
        check("R7 idx held", int'(idx), exp_idx);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1 reset valid", int'(valid), 0);
        check("R1 reset idx", int'(idx), 0);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check("R1 idle valid", int'(valid), 0);
        // First request uses state 1 (R1, R2)
        do_req(0, 1'b0);
        for (int w = 0; w <= 20; w++)
            for (int k = 0; k < 5; k++)
                do_req(w, 1'b0);
        // Long idle gap: state must not advance per clock (R2)
        repeat (50) @(negedge clk);
        check("R2 no valid while idle", int'(valid), 0);
        check("R7 idx held across idle", int'(idx), int'(N - 1));
        do_req(3, 1'b0);
        do_req(7, 1'b1);
        do_req(7, 1'b0);
        do_req(1, 1'b1);
        do_req(17, 1'b0);
        do_req(0, 1'b0);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule